// File: doc/BRIEF.md
# Store-and-forward mesh router

This router sits at one node of a two-by-two mesh network-on-chip. It has a neighbour link in the X direction, a neighbour link in the Y direction, and a local attachment. The local attachment is split into two channels. Head and tail flits use a channel to the network interface, and data flits use a channel that runs straight to and from the cache. As a result, the network interface keeps only the framing flits of a packet and never buffers its payload.

The router takes in one complete packet, holds it in a single-packet store, and only then sends it out. The output is chosen from the destination coordinates in the head flit, with X resolved before Y. A packet that arrives from a neighbour is either forwarded whole to the other neighbour or ejected in three phases: the head goes to the network interface, the data goes to the cache, and the tail goes to the network interface. A packet injected locally arrives the other way round. The head comes from the network interface and the data comes from the cache. The router then raises a tail request, and the network interface answers it with the tail.

Top module: `mesh_sf_router`

## Requirements
- R1: After reset every output valid and `ni_tail_req` are low, and every input ready is low while no input offers a flit.
- R2: The flit type sits in the top two bits of a flit: head 01, data 10, tail 11. In a head flit, bits [CW-1:0] hold the destination X and bits [2*CW-1:CW] hold the destination Y. If destination X differs from the router's own X, the packet leaves on the X link. Otherwise, if destination Y differs from its own Y, the packet leaves on the Y link. Otherwise it is ejected locally.
- R3: No output valid is raised before the tail flit of the held packet has been accepted. While a packet is being output, every input ready is low.
- R4: The head flit carries the data-flit count in bits [4*CW+LEN_W-1:4*CW]. After a head has been accepted from the network interface, `cache_in_ready` stays high and `ni_in_ready` stays low until exactly that many data flits have been accepted.
- R5: Once the last data flit of an injected packet has been accepted, `ni_tail_req` and `ni_in_ready` are high until the tail flit is accepted.
- R6: A locally addressed packet is ejected in order: the head on `ni_out`, then each data flit on `cache_out` in arrival order, then the tail on `ni_out`.
- R7: A packet routed to a neighbour leaves on that link as count+2 flits, unchanged and in arrival order.
- R8: When idle with several inputs offering a head, the X link is served first, then the Y link, then the network interface. At most one input ready is high at any time.
- R9: An output valid that is not taken stays high in the next cycle, with its flit unchanged.
- R10: A head with a count of zero is followed directly by its tail. For injection, the tail request is raised right after the head. On ejection, `cache_out_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in_valid | input | 1 | X link inbound flit offered |
| x_in_ready | output | 1 | X link inbound flit taken |
| x_in_flit | input | FLIT_W | X link inbound flit |
| x_out_valid | output | 1 | X link outbound flit offered |
| x_out_ready | input | 1 | X link outbound flit taken |
| x_out_flit | output | FLIT_W | X link outbound flit |
| y_in_valid | input | 1 | Y link inbound flit offered |
| y_in_ready | output | 1 | Y link inbound flit taken |
| y_in_flit | input | FLIT_W | Y link inbound flit |
| y_out_valid | output | 1 | Y link outbound flit offered |
| y_out_ready | input | 1 | Y link outbound flit taken |
| y_out_flit | output | FLIT_W | Y link outbound flit |
| ni_in_valid | input | 1 | Head or tail offered by the network interface |
| ni_in_ready | output | 1 | Head or tail taken from the network interface |
| ni_in_flit | input | FLIT_W | Head or tail from the network interface |
| ni_out_valid | output | 1 | Head or tail offered to the network interface |
| ni_out_ready | input | 1 | Network interface takes head or tail |
| ni_out_flit | output | FLIT_W | Head or tail to the network interface |
| ni_tail_req | output | 1 | Request for the tail of the injected packet |
| cache_in_valid | input | 1 | Data flit offered by the cache |
| cache_in_ready | output | 1 | Data flit taken from the cache |
| cache_in_flit | input | FLIT_W | Data flit from the cache |
| cache_out_valid | output | 1 | Data flit offered to the cache |
| cache_out_ready | input | 1 | Cache takes data flit |
| cache_out_flit | output | FLIT_W | Data flit to the cache |

## Verification
The bench places the router at coordinates (1,0) and sets DATA_MAX to 4. With those coordinates, packets can be built for every routing outcome: X only, Y only, X then Y, and local. The smaller data limit means a packet that fills the store completely needs only four data flits. FLIT_W stays at 32, CW at 1 and LEN_W at 4, so the head layout in the requirements fits a 32-bit word, and all other options keep their default values: X before Y, link-first priority.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   // Identifies the router side a flit comes from or goes to.
   typedef enum logic [1:0] {
      P_X = 2'b00,
      P_Y = 2'b01,
      P_L = 2'b10
   } port_e;

   // Packet life cycle inside the router.
   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_RX_NET   = 3'd1,
      S_INJ_DATA = 3'd2,
      S_INJ_TAIL = 3'd3,
      S_FWD_NET  = 3'd4,
      S_EJ_HEAD  = 3'd5,
      S_EJ_DATA  = 3'd6,
      S_EJ_TAIL  = 3'd7
   } state_e;

endpackage

// File: rtl/sfr_route.sv
module sfr_route
   import sfr_pkg::*;
#(
   parameter int CW       = 1,
   parameter int MY_X     = 0,
   parameter int MY_Y     = 0,
   parameter bit XY_FIRST = 1'b1
) (
   input  logic [CW-1:0] dst_x,
   input  logic [CW-1:0] dst_y,
   output port_e         sel
);
   localparam logic [CW-1:0] OWN_X = CW'(MY_X);
   localparam logic [CW-1:0] OWN_Y = CW'(MY_Y);

   generate
      if (XY_FIRST) begin : g_xy
         always_comb begin
            if (dst_x != OWN_X)      sel = P_X;
            else if (dst_y != OWN_Y) sel = P_Y;
            else                     sel = P_L;
         end
      end else begin : g_yx
         always_comb begin
            if (dst_y != OWN_Y)      sel = P_Y;
            else if (dst_x != OWN_X) sel = P_X;
            else                     sel = P_L;
         end
      end
   endgenerate

endmodule

// File: rtl/sfr_arb.sv
module sfr_arb
   import sfr_pkg::*;
#(
   parameter bit LOCAL_FIRST = 1'b0
) (
   input  logic  x_req,
   input  logic  y_req,
   input  logic  l_req,
   output logic  any,
   output port_e win
);
   assign any = x_req | y_req | l_req;

   generate
      if (LOCAL_FIRST) begin : g_local_first
         always_comb begin
            if (l_req)      win = P_L;
            else if (x_req) win = P_X;
            else if (y_req) win = P_Y;
            else            win = P_X;
         end
      end else begin : g_link_first
         always_comb begin
            if (x_req)      win = P_X;
            else if (y_req) win = P_Y;
            else if (l_req) win = P_L;
            else            win = P_X;
         end
      end
   endgenerate

endmodule

// File: rtl/sfr_store.sv
module sfr_store #(
   parameter int W     = 32,
   parameter int DEPTH = 10,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] slot [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slot[waddr] <= wdata;
   end

   assign rdata = slot[raddr];

   // R7: a packet never spills past the single-packet store
   p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/mesh_sf_router.sv
module mesh_sf_router
   import sfr_pkg::*;
#(
   parameter int FLIT_W      = 32,
   parameter int CW          = 1,
   parameter int LEN_W       = 4,
   parameter int DATA_MAX    = 8,
   parameter int MY_X        = 0,
   parameter int MY_Y        = 0,
   parameter bit XY_FIRST    = 1'b1,
   parameter bit LOCAL_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              x_in_valid,
   output logic              x_in_ready,
   input  logic [FLIT_W-1:0] x_in_flit,
   output logic              x_out_valid,
   input  logic              x_out_ready,
   output logic [FLIT_W-1:0] x_out_flit,
   input  logic              y_in_valid,
   output logic              y_in_ready,
   input  logic [FLIT_W-1:0] y_in_flit,
   output logic              y_out_valid,
   input  logic              y_out_ready,
   output logic [FLIT_W-1:0] y_out_flit,
   input  logic              ni_in_valid,
   output logic              ni_in_ready,
   input  logic [FLIT_W-1:0] ni_in_flit,
   output logic              ni_out_valid,
   input  logic              ni_out_ready,
   output logic [FLIT_W-1:0] ni_out_flit,
   output logic              ni_tail_req,
   input  logic              cache_in_valid,
   output logic              cache_in_ready,
   input  logic [FLIT_W-1:0] cache_in_flit,
   output logic              cache_out_valid,
   input  logic              cache_out_ready,
   output logic [FLIT_W-1:0] cache_out_flit
);
   localparam int DEPTH  = DATA_MAX + 2;
   localparam int AW     = $clog2(DEPTH);
   localparam int CNT_LO = 4 * CW;

   // elaboration-time parameter checks
   generate
      if (DATA_MAX < 1 || DATA_MAX >= (1 << LEN_W)) begin : g_bad_len
         $error("DATA_MAX must be at least 1 and fit in LEN_W bits");
      end
      if (FLIT_W < 2 + CNT_LO + LEN_W) begin : g_bad_width
         $error("FLIT_W too narrow for type, coordinates and count");
      end
      if (MY_X >= (1 << CW) || MY_Y >= (1 << CW) || MY_X < 0 || MY_Y < 0) begin : g_bad_coord
         $error("own coordinates do not fit in CW bits");
      end
   endgenerate

   state_e st_q;
   port_e  src_q, dst_q;
   logic [LEN_W-1:0] cnt_q;
   logic [AW-1:0]    wr_q, rd_q;

   logic              arb_any;
   port_e             arb_win;
   port_e             head_route;
   logic [FLIT_W-1:0] head_flit, wdata, rdata;
   logic [LEN_W-1:0]  head_cnt_raw, head_cnt;
   logic [AW-1:0]     last_idx, data_last, waddr;
   logic              in_acc, out_acc, we;
   state_e            send_state;

   // ---------------- head selection and routing ----------------
   sfr_arb #(.LOCAL_FIRST(LOCAL_FIRST)) u_arb (
      .x_req (x_in_valid  && st_q == S_IDLE),
      .y_req (y_in_valid  && st_q == S_IDLE),
      .l_req (ni_in_valid && st_q == S_IDLE),
      .any   (arb_any),
      .win   (arb_win)
   );

   always_comb begin
      case (arb_win)
         P_X:     head_flit = x_in_flit;
         P_Y:     head_flit = y_in_flit;
         default: head_flit = ni_in_flit;
      endcase
   end

   assign head_cnt_raw = head_flit[CNT_LO +: LEN_W];
   assign head_cnt     = (head_cnt_raw > LEN_W'(DATA_MAX)) ? LEN_W'(DATA_MAX) : head_cnt_raw;

   sfr_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y), .XY_FIRST(XY_FIRST)) u_route (
      .dst_x (head_flit[CW-1:0]),
      .dst_y (head_flit[2*CW-1:CW]),
      .sel   (head_route)
   );

   assign last_idx   = AW'(cnt_q) + AW'(1);
   assign data_last  = AW'(cnt_q);
   assign send_state = (dst_q == P_L) ? S_EJ_HEAD : S_FWD_NET;

   // ---------------- handshake decode ----------------
   always_comb begin
      x_in_ready      = 1'b0;
      y_in_ready      = 1'b0;
      ni_in_ready     = 1'b0;
      cache_in_ready  = 1'b0;
      ni_tail_req     = 1'b0;
      x_out_valid     = 1'b0;
      y_out_valid     = 1'b0;
      ni_out_valid    = 1'b0;
      cache_out_valid = 1'b0;
      case (st_q)
         S_IDLE: begin
            x_in_ready  = arb_any && arb_win == P_X;
            y_in_ready  = arb_any && arb_win == P_Y;
            ni_in_ready = arb_any && arb_win == P_L;
         end
         S_RX_NET: begin
            x_in_ready = (src_q == P_X);
            y_in_ready = (src_q == P_Y);
         end
         S_INJ_DATA: cache_in_ready = 1'b1;
         S_INJ_TAIL: begin
            ni_in_ready = 1'b1;
            ni_tail_req = 1'b1;
         end
         S_FWD_NET: begin
            x_out_valid = (dst_q == P_X);
            y_out_valid = (dst_q == P_Y);
         end
         S_EJ_HEAD, S_EJ_TAIL: ni_out_valid = 1'b1;
         S_EJ_DATA: cache_out_valid = 1'b1;
         default: ;
      endcase
   end

   assign in_acc = (x_in_valid && x_in_ready) || (y_in_valid && y_in_ready) ||
                   (ni_in_valid && ni_in_ready) || (cache_in_valid && cache_in_ready);
   assign out_acc = (x_out_valid && x_out_ready) || (y_out_valid && y_out_ready) ||
                    (ni_out_valid && ni_out_ready) || (cache_out_valid && cache_out_ready);

   always_comb begin
      case (st_q)
         S_IDLE:     wdata = head_flit;
         S_RX_NET:   wdata = (src_q == P_X) ? x_in_flit : y_in_flit;
         S_INJ_DATA: wdata = cache_in_flit;
         default:    wdata = ni_in_flit;
      endcase
   end

   assign we    = in_acc;
   assign waddr = (st_q == S_IDLE) ? '0 : wr_q;

   sfr_store #(.W(FLIT_W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (rd_q),
      .rdata (rdata)
   );

   assign x_out_flit     = rdata;
   assign y_out_flit     = rdata;
   assign ni_out_flit    = rdata;
   assign cache_out_flit = rdata;

   // ---------------- packet sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         src_q <= P_X;
         dst_q <= P_X;
         cnt_q <= '0;
         wr_q  <= '0;
         rd_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (in_acc) begin
               src_q <= arb_win;
               dst_q <= head_route;
               cnt_q <= head_cnt;
               wr_q  <= AW'(1);
               if (arb_win == P_L)
                  st_q <= (head_cnt == '0) ? S_INJ_TAIL : S_INJ_DATA;
               else
                  st_q <= S_RX_NET;
            end
            S_RX_NET: if (in_acc) begin
               wr_q <= wr_q + AW'(1);
               if (wr_q == last_idx) begin
                  rd_q <= '0;
                  st_q <= send_state;
               end
            end
            S_INJ_DATA: if (in_acc) begin
               wr_q <= wr_q + AW'(1);
               if (wr_q == data_last) st_q <= S_INJ_TAIL;
            end
            S_INJ_TAIL: if (in_acc) begin
               rd_q <= '0;
               st_q <= send_state;
            end
            S_FWD_NET: if (out_acc) begin
               rd_q <= rd_q + AW'(1);
               if (rd_q == last_idx) st_q <= S_IDLE;
            end
            S_EJ_HEAD: if (out_acc) begin
               rd_q <= rd_q + AW'(1);
               st_q <= (cnt_q == '0) ? S_EJ_TAIL : S_EJ_DATA;
            end
            S_EJ_DATA: if (out_acc) begin
               rd_q <= rd_q + AW'(1);
               if (rd_q == data_last) st_q <= S_EJ_TAIL;
            end
            S_EJ_TAIL: if (out_acc) st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // ---------------- properties ----------------
   p_single_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({x_in_ready, y_in_ready, ni_in_ready, cache_in_ready}) <= 1);

   p_no_cut_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in_ready || y_in_ready || ni_in_ready || cache_in_ready) |->
      !(x_out_valid || y_out_valid || ni_out_valid || cache_out_valid));

   p_x_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (x_out_valid && !x_out_ready) |=> (x_out_valid && $stable(x_out_flit)));

   p_cache_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cache_out_valid && !cache_out_ready) |=> (cache_out_valid && $stable(cache_out_flit)));

   p_tail_req_after_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ni_tail_req) |->
      $past((cache_in_valid && cache_in_ready) || (ni_in_valid && ni_in_ready)));

   p_eject_head_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cache_out_valid) |-> $past(ni_out_valid && ni_out_ready));

endmodule

// File: tb/tb_mesh_sf_router.sv
`timescale 1ns/1ps
module tb_mesh_sf_router;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // index 0: X link, 1: Y link, 2: network interface, 3: cache
   logic         iv   [4];
   logic [W-1:0] id   [4];
   logic         ir   [4];
   logic         ov   [4];
   logic [W-1:0] od   [4];
   logic         ordy [4];
   logic         treq;

   int total = 0;
   int bad   = 0;

   mesh_sf_router #(
      .FLIT_W(W), .CW(1), .LEN_W(4), .DATA_MAX(4), .MY_X(1), .MY_Y(0)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .x_in_valid(iv[0]), .x_in_ready(ir[0]), .x_in_flit(id[0]),
      .x_out_valid(ov[0]), .x_out_ready(ordy[0]), .x_out_flit(od[0]),
      .y_in_valid(iv[1]), .y_in_ready(ir[1]), .y_in_flit(id[1]),
      .y_out_valid(ov[1]), .y_out_ready(ordy[1]), .y_out_flit(od[1]),
      .ni_in_valid(iv[2]), .ni_in_ready(ir[2]), .ni_in_flit(id[2]),
      .ni_out_valid(ov[2]), .ni_out_ready(ordy[2]), .ni_out_flit(od[2]),
      .ni_tail_req(treq),
      .cache_in_valid(iv[3]), .cache_in_ready(ir[3]), .cache_in_flit(id[3]),
      .cache_out_valid(ov[3]), .cache_out_ready(ordy[3]), .cache_out_flit(od[3])
   );

   function automatic logic [W-1:0] mk_head(input int dx, input int dy, input int cnt, input int tag);
      logic [W-1:0] f;
      f = '0;
      f[31:30] = 2'b01;
      f[29:8]  = 22'(tag);
      f[7:4]   = 4'(cnt);
      f[3:2]   = 2'b10;
      f[1]     = 1'(dy);
      f[0]     = 1'(dx);
      return f;
   endfunction

   function automatic logic [W-1:0] mk_data(input int n);
      return {2'b10, 30'(n * 7919 + 3)};
   endfunction

   function automatic logic [W-1:0] mk_tail(input int n);
      return {2'b11, 30'(n + 1000)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic put(input int p, input logic [W-1:0] f, input string req);
      int n;
      @(negedge clk);
      iv[p] = 1'b1;
      id[p] = f;
      #1;
      n = 0;
      while (!ir[p] && n < 60) begin
         @(negedge clk);
         #1;
         n++;
      end
      chk(ir[p], req, W'(ir[p]), W'(1));
      @(posedge clk);
      #1;
      iv[p] = 1'b0;
   endtask

   task automatic get(input int p, input logic [W-1:0] exp, input string req);
      int n;
      @(negedge clk);
      ordy[p] = 1'b1;
      #1;
      n = 0;
      while (!ov[p] && n < 60) begin
         @(negedge clk);
         #1;
         n++;
      end
      chk(ov[p] && od[p] == exp, req, od[p], exp);
      @(posedge clk);
      #1;
      ordy[p] = 1'b0;
   endtask

   function automatic logic [3:0] outs();
      return {ov[3], ov[2], ov[1], ov[0]};
   endfunction

   function automatic logic [3:0] rdys();
      return {ir[3], ir[2], ir[1], ir[0]};
   endfunction

   // locally injected packet forwarded to a neighbour port
   task automatic t_inject(input int dx, input int dy, input int cnt, input int port, input string req);
      logic [W-1:0] hd;
      hd = mk_head(dx, dy, cnt, 40 + cnt);
      put(2, hd, "R4 head");
      @(negedge clk); #1;
      chk(ir[3] == 1'b1 && ir[2] == 1'b0, "R4 cache ready after head", W'(rdys()), W'(4'b1000));
      for (int i = 0; i < cnt; i++) put(3, mk_data(i), "R4 data");
      @(negedge clk); #1;
      chk(treq == 1'b1 && ir[2] == 1'b1, "R5 tail request", W'({treq, ir[2]}), W'(2'b11));
      chk(outs() == 4'b0, "R3 no output before tail", W'(outs()), W'(0));
      put(2, mk_tail(cnt), "R5 tail");
      get(port, hd, req);
      for (int i = 0; i < cnt; i++) get(port, mk_data(i), "R7 data order");
      get(port, mk_tail(cnt), "R7 tail");
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk(outs() == 4'b0, "R1 output valids", W'(outs()), W'(0));
      chk(treq == 1'b0, "R1 tail request", W'(treq), W'(0));
      chk(rdys() == 4'b0, "R1 input readies", W'(rdys()), W'(0));
   endtask

   task automatic t_transit_eject();
      logic [W-1:0] hd;
      hd = mk_head(1, 0, 3, 77);
      put(0, hd, "R6 head from X");
      for (int i = 0; i < 3; i++) put(0, mk_data(10 + i), "R6 data from X");
      put(0, mk_tail(77), "R6 tail from X");
      get(2, hd, "R6 head ejected to ni");
      for (int i = 0; i < 3; i++) get(3, mk_data(10 + i), "R6 data ejected to cache");
      @(negedge clk); #1;
      chk(ov[2] == 1'b1 && ov[3] == 1'b0, "R6 tail next on ni", W'({ov[3], ov[2]}), W'(2'b01));
      get(2, mk_tail(77), "R6 tail ejected to ni");
   endtask

   task automatic t_zero();
      logic [W-1:0] hd;
      hd = mk_head(1, 0, 0, 5);
      put(2, hd, "R10 zero head");
      @(negedge clk); #1;
      chk(treq == 1'b1 && ir[3] == 1'b0, "R10 tail request right after head", W'({treq, ir[3]}), W'(2'b10));
      put(2, mk_tail(5), "R10 zero tail");
      get(2, hd, "R10 head ejected");
      @(negedge clk); #1;
      chk(ov[3] == 1'b0 && ov[2] == 1'b1, "R10 no cache data", W'({ov[3], ov[2]}), W'(2'b01));
      get(2, mk_tail(5), "R10 tail ejected");
   endtask

   task automatic t_backpressure();
      logic [W-1:0] hd;
      hd = mk_head(0, 0, 1, 9);
      put(1, hd, "R9 head from Y");
      put(1, mk_data(99), "R9 data from Y");
      put(1, mk_tail(9), "R9 tail from Y");
      @(negedge clk);
      iv[2] = 1'b1;
      id[2] = mk_head(1, 0, 0, 1);
      #1;
      chk(rdys() == 4'b0, "R3 inputs blocked while held", W'(rdys()), W'(0));
      iv[2] = 1'b0;
      chk(ov[0] == 1'b1 && od[0] == hd, "R9 head offered on X", od[0], hd);
      @(negedge clk); #1;
      chk(ov[0] == 1'b1 && od[0] == hd, "R9 held one cycle", od[0], hd);
      @(negedge clk); #1;
      chk(ov[0] == 1'b1 && od[0] == hd, "R9 held two cycles", od[0], hd);
      get(0, hd, "R9 head taken");
      get(0, mk_data(99), "R9 data taken");
      get(0, mk_tail(9), "R9 tail taken");
   endtask

   task automatic t_arb();
      logic [W-1:0] hd;
      hd = mk_head(1, 0, 0, 3);
      @(negedge clk);
      iv[0] = 1'b1; id[0] = hd;
      iv[1] = 1'b1; id[1] = mk_head(0, 0, 0, 4);
      iv[2] = 1'b1; id[2] = mk_head(0, 0, 0, 6);
      #1;
      chk(rdys() == 4'b0001, "R8 X link wins", W'(rdys()), W'(4'b0001));
      @(posedge clk); #1;
      iv[0] = 1'b0;
      @(negedge clk); #1;
      chk(ir[1] == 1'b0 && ir[2] == 1'b0, "R8 losers stay blocked", W'({ir[2], ir[1]}), W'(0));
      iv[1] = 1'b0;
      iv[2] = 1'b0;
      put(0, mk_tail(3), "R8 tail from X");
      get(2, hd, "R8 winner head ejected");
      get(2, mk_tail(3), "R8 winner tail ejected");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R1 watchdog", W'(0), W'(1));
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         iv[i] = 1'b0;
         id[i] = '0;
         ordy[i] = 1'b0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inject(0, 0, 2, 0, "R2 dst west to X");
      t_inject(1, 1, 4, 1, "R2 dst north to Y full store");
      t_inject(0, 1, 1, 0, "R2 diagonal goes X first");
      t_transit_eject();
      t_zero();
      t_backpressure();
      t_arb();
      repeat (3) @(negedge clk);
      #1;
      chk(outs() == 4'b0, "R7 idle after traffic", W'(outs()), W'(0));
      summary();
      $finish;
   end

endmodule